// File: doc/BRIEF.md
# Power-Level Trigger for IQ Samples

The block watches a stream of signed I/Q sample pairs and raises a one-clock trigger when the signal power meets a level condition. For each sample marked valid it forms the instantaneous power I²+Q². That power feeds first-order exponential smoothing filters whose speed is set by shift values.

In absolute mode, one smoothed power is compared with a signed threshold. The polarity input chooses whether the trigger is for the level rising above the threshold or for the level dropping back to it or below it.

In relative mode, a fast filter and a slow filter run side by side, and their difference is compared with the threshold. A sudden step in level makes the fast filter pull ahead of the slow one for a while, so the difference forms a transient pulse. The sign of the threshold chooses the direction: a threshold of zero or more arms the block for upward steps, and a negative threshold arms it for downward steps. Relative mode always uses the rising polarity, whatever the polarity input requests.

The arm input, or any change of mode, clears both filters and the compare history. After that, the trigger can only fire once the compare condition has been seen false.

Top module: `lvl_trigger`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `trig_out` is 0.
- R2: A sample enters the filters only on a cycle with `smp_vld` high; I/Q values presented with `smp_vld` low change neither the filters nor the trigger.
- R3: Each filter holds state y with FB=8 fraction bits and updates on each accepted sample as y ← y + (((I²+Q²)·2^FB − y) >>> k), with an arithmetic shift. `cfg_k_abs` gives k for the single filter in absolute mode. `cfg_k_fast` and `cfg_k_slow` give k for the two filters in relative mode.
- R4: In absolute mode (`cfg_rel`=0) with `cfg_fall`=0, the compare is true when y > `cfg_thr`·2^FB. A trigger caused by the sample accepted at clock edge n shows on `trig_out` after edge n+3, for one clock.
- R5: In absolute mode with `cfg_fall`=1, the compare is true when y ≤ `cfg_thr`·2^FB, so a drop in level triggers and a rise does not.
- R6: In relative mode (`cfg_rel`=1) with `cfg_thr` ≥ 0, the compare is true when y_fast − y_slow > `cfg_thr`·2^FB, so an upward power step triggers.
- R7: In relative mode with `cfg_thr` < 0, the compare is true when y_slow − y_fast > |`cfg_thr`|·2^FB, so a downward power step triggers.
- R8: In relative mode `cfg_fall` has no effect; the behaviour is that of rising polarity.
- R9: `trig_out` is high for exactly one clock, on a false-to-true change of the compare result. It does not fire again until the compare result has been false.
- R10: A one-cycle `arm` pulse, or any change of `cfg_rel`, zeroes both filters, drops a sample accepted in the same cycle and holds `trig_out` low for the next two clocks. After that, a trigger needs the compare to go from false, evaluated on the zeroed filters, to true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | I/Q pair valid strobe |
| smp_i | input | IW (12) | Signed in-phase sample |
| smp_q | input | IW (12) | Signed quadrature sample |
| cfg_rel | input | 1 | 0 = absolute mode, 1 = relative mode |
| cfg_fall | input | 1 | Polarity request: 0 = rising, 1 = falling (absolute mode only) |
| cfg_k_abs | input | KW (4) | Shift for the absolute-mode filter |
| cfg_k_fast | input | KW (4) | Shift for the fast relative-mode filter |
| cfg_k_slow | input | KW (4) | Shift for the slow relative-mode filter |
| cfg_thr | input | 2·IW+1 (25) | Signed threshold in power units |
| arm | input | 1 | Re-arm pulse: clears filters and compare history |
| trig_out | output | 1 | One-cycle trigger pulse |

## Verification
A clear and a sample update can land in the same cycle: `arm` is pulsed together with `smp_vld` carrying a strong sample, while the filter already sits above a positive threshold. The bench expects the sample to be dropped and the history to be rebuilt from zeroed filters. The next strong sample must therefore trigger. If the sample had been absorbed, or the old average kept, the compare would already be true and the trigger would stay blocked. A double toggle of `cfg_rel` is judged the same way, and constrained-random configurations with held power steps are compared sample by sample against a bench model of the filters.

// File: rtl/lvtrig_pkg.sv
package lvtrig_pkg;
  typedef enum logic {
    LVL_ABS = 1'b0,
    LVL_REL = 1'b1
  } lvl_mode_e;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/lvtrig_power.sv
// Registered instantaneous power of one I/Q pair.
module lvtrig_power #(
  parameter int IW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 in_vld,
  input  logic signed [IW-1:0] in_i,
  input  logic signed [IW-1:0] in_q,
  output logic                 out_vld,
  output logic [2*IW-1:0]      out_pwr
);
  localparam int PW = 2 * IW;

  logic signed [PW-1:0] sq_i;
  logic signed [PW-1:0] sq_q;

  always_comb begin
    sq_i = in_i * in_i;
    sq_q = in_q * in_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      out_vld <= 1'b0;
      out_pwr <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_pwr <= $unsigned(sq_i) + $unsigned(sq_q);
      end
    end
  end
endmodule

// File: rtl/lvtrig_ema.sv
// First-order exponential average with FB fraction bits.
module lvtrig_ema #(
  parameter int PW = 24,
  parameter int FB = 8,
  parameter int KW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             upd,
  input  logic [KW-1:0]    k,
  input  logic [PW-1:0]    x,
  output logic [PW+FB-1:0] y
);
  localparam int SW = PW + FB;

  logic signed [SW:0] err;
  logic signed [SW:0] step;
  logic signed [SW:0] nxt;

  always_comb begin
    err  = $signed({1'b0, x, {FB{1'b0}}}) - $signed({1'b0, y});
    step = err >>> k;
    nxt  = $signed({1'b0, y}) + step;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      y <= '0;
    end else if (upd) begin
      y <= nxt[SW-1:0];
    end
  end
endmodule

// File: rtl/lvtrig_cmp.sv
// Level / difference comparison, registered. A clear forces the result true
// so that the edge stage treats the history as blocked.
module lvtrig_cmp
  import lvtrig_pkg::*;
#(
  parameter int SW = 32,
  parameter int TW = 25,
  parameter int FB = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  lvl_mode_e            mode,
  input  edge_pol_e            pol,
  input  logic [SW-1:0]        y_fast,
  input  logic [SW-1:0]        y_slow,
  input  logic signed [TW-1:0] thr,
  output logic                 hit
);
  localparam int CW = SW + 2;

  logic signed [CW-1:0] lvl_f;
  logic signed [CW-1:0] lvl_s;
  logic signed [CW-1:0] thr_s;
  logic signed [CW-1:0] mag_s;
  logic signed [CW-1:0] diff;
  logic                 neg_thr;
  logic                 abs_above;
  logic                 hit_nxt;

  always_comb begin
    lvl_f     = $signed({2'b00, y_fast});
    lvl_s     = $signed({2'b00, y_slow});
    thr_s     = CW'(thr) <<< FB;
    neg_thr   = thr[TW-1];
    mag_s     = neg_thr ? -thr_s : thr_s;
    diff      = neg_thr ? (lvl_s - lvl_f) : (lvl_f - lvl_s);
    abs_above = lvl_f > thr_s;
    if (mode == LVL_REL) begin
      hit_nxt = diff > mag_s;
    end else if (pol == EDGE_FALL) begin
      hit_nxt = !abs_above;
    end else begin
      hit_nxt = abs_above;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hit <= 1'b1;
    end else begin
      hit <= hit_nxt;
    end
  end
endmodule

// File: rtl/lvtrig_edge.sv
// False-to-true detector producing a one-clock pulse.
module lvtrig_edge (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic hit,
  output logic pulse
);
  logic blocked;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pulse   <= 1'b0;
      blocked <= 1'b1;
    end else begin
      pulse   <= hit && !blocked;
      blocked <= hit;
    end
  end
endmodule

// File: rtl/lvl_trigger.sv
module lvl_trigger
  import lvtrig_pkg::*;
#(
  parameter int IW = 12,
  parameter int FB = 8,
  parameter int KW = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   smp_vld,
  input  logic signed [IW-1:0]   smp_i,
  input  logic signed [IW-1:0]   smp_q,
  input  logic                   cfg_rel,
  input  logic                   cfg_fall,
  input  logic [KW-1:0]          cfg_k_abs,
  input  logic [KW-1:0]          cfg_k_fast,
  input  logic [KW-1:0]          cfg_k_slow,
  input  logic signed [2*IW:0]   cfg_thr,
  input  logic                   arm,
  output logic                   trig_out
);
  localparam int PW = 2 * IW;
  localparam int SW = PW + FB;
  localparam int TW = PW + 1;

  lvl_mode_e     mode;
  edge_pol_e     pol_eff;
  logic          rel_q;
  logic          clr;
  logic          pwr_vld;
  logic [PW-1:0] pwr;
  logic [KW-1:0] k_main;
  logic [SW-1:0] y_a;
  logic [SW-1:0] y_b;
  logic          hit;

  always_comb begin
    mode    = lvl_mode_e'(cfg_rel);
    pol_eff = (mode == LVL_REL) ? EDGE_RISE : edge_pol_e'(cfg_fall);
    clr     = arm || (cfg_rel != rel_q);
    k_main  = (mode == LVL_REL) ? cfg_k_fast : cfg_k_abs;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_q <= 1'b0;
    end else begin
      rel_q <= cfg_rel;
    end
  end

  lvtrig_power #(.IW(IW)) u_pwr (
    .clk(clk), .rst(rst), .clr(clr), .in_vld(smp_vld),
    .in_i(smp_i), .in_q(smp_q), .out_vld(pwr_vld), .out_pwr(pwr)
  );

  lvtrig_ema #(.PW(PW), .FB(FB), .KW(KW)) u_ema_a (
    .clk(clk), .rst(rst), .clr(clr), .upd(pwr_vld),
    .k(k_main), .x(pwr), .y(y_a)
  );

  lvtrig_ema #(.PW(PW), .FB(FB), .KW(KW)) u_ema_b (
    .clk(clk), .rst(rst), .clr(clr), .upd(pwr_vld),
    .k(cfg_k_slow), .x(pwr), .y(y_b)
  );

  lvtrig_cmp #(.SW(SW), .TW(TW), .FB(FB)) u_cmp (
    .clk(clk), .rst(rst), .clr(clr), .mode(mode), .pol(pol_eff),
    .y_fast(y_a), .y_slow(y_b), .thr(cfg_thr), .hit(hit)
  );

  lvtrig_edge u_edge (
    .clk(clk), .rst(rst), .clr(clr), .hit(hit), .pulse(trig_out)
  );
endmodule

// File: rtl/lvl_trigger_chk.sv
module lvl_trigger_chk #(
  parameter int PW = 24,
  parameter int FB = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_vld,
  input logic             clr,
  input logic             pwr_vld,
  input logic [PW+FB-1:0] y_a,
  input logic [PW+FB-1:0] y_b,
  input logic             trig_out
);
  localparam logic [PW+FB-1:0] YMAX = {{PW{1'b1}}, {FB{1'b0}}};

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    trig_out |=> !trig_out); // R9

  AST_CLEAR_QUIET_1: assert property (@(posedge clk) disable iff (rst)
    clr |=> !trig_out); // R10

  AST_CLEAR_QUIET_2: assert property (@(posedge clk) disable iff (rst)
    clr |=> ##1 !trig_out); // R10

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!pwr_vld && !clr) |=> ($stable(y_a) && $stable(y_b))); // R2

  AST_STROBE_PIPE: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !clr) |=> pwr_vld); // R2

  AST_FILTER_BOUND: assert property (@(posedge clk) disable iff (rst)
    (y_a <= YMAX) && (y_b <= YMAX)); // R3
endmodule

bind lvl_trigger lvl_trigger_chk #(.PW(PW), .FB(FB)) u_chk (
  .clk(clk), .rst(rst), .smp_vld(smp_vld), .clr(clr), .pwr_vld(pwr_vld),
  .y_a(y_a), .y_b(y_b), .trig_out(trig_out)
);

// File: tb/sim_lvl_trigger.sv
`timescale 1ns/1ps
module sim_lvl_trigger;
  localparam int IW = 12;
  localparam int FB = 8;
  localparam int KW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic signed [IW-1:0] smp_i = '0;
  logic signed [IW-1:0] smp_q = '0;
  logic cfg_rel = 1'b0;
  logic cfg_fall = 1'b0;
  logic [KW-1:0] cfg_k_abs = 4'd2;
  logic [KW-1:0] cfg_k_fast = 4'd1;
  logic [KW-1:0] cfg_k_slow = 4'd5;
  logic signed [2*IW:0] cfg_thr = '0;
  logic arm = 1'b0;
  logic trig_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  // bench model state
  longint ya = 0;
  longint yb = 0;
  bit     prev_hit = 1'b1;

  always #2.5 clk = ~clk;

  lvl_trigger #(.IW(IW), .FB(FB), .KW(KW)) u0 (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_i(smp_i), .smp_q(smp_q),
    .cfg_rel(cfg_rel), .cfg_fall(cfg_fall), .cfg_k_abs(cfg_k_abs),
    .cfg_k_fast(cfg_k_fast), .cfg_k_slow(cfg_k_slow), .cfg_thr(cfg_thr),
    .arm(arm), .trig_out(trig_out)
  );

  function automatic longint f_ema(longint y, longint x, int k);
    return y + (((x <<< FB) - y) >>> k);
  endfunction

  function automatic bit f_hit(bit rel, bit fall, longint a, longint b, longint thr);
    longint ts;
    bit above;
    ts = thr * (longint'(1) <<< FB);
    if (rel) begin
      if (thr < 0) return (b - a) > -ts;
      return (a - b) > ts;
    end
    above = a > ts;
    return fall ? !above : above;
  endfunction

  function automatic bit cur_hit();
    return f_hit(cfg_rel, cfg_fall, ya, yb, longint'(cfg_thr));
  endfunction

  task automatic chk(bit got, bit exp, string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: trig_out=%0b expected %0b at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  // caller sits just after a negedge
  task automatic model_clear();
    ya = 0;
    yb = 0;
    prev_hit = cur_hit();
  endtask

  task automatic do_arm();
    arm = 1'b1;
    @(posedge clk); @(negedge clk);
    arm = 1'b0;
    repeat (3) @(negedge clk);
    model_clear();
  endtask

  task automatic set_mode(bit rel);
    cfg_rel = rel;
    repeat (4) @(negedge clk);
    model_clear();
  endtask

  task automatic send(int amp_i, int amp_q, string tag);
    longint p;
    bit h;
    bit exp;
    int ka;
    p  = longint'(amp_i) * amp_i + longint'(amp_q) * amp_q;
    ka = cfg_rel ? int'(cfg_k_fast) : int'(cfg_k_abs);
    ya = f_ema(ya, p, ka);
    yb = f_ema(yb, p, int'(cfg_k_slow));
    h  = cur_hit();
    exp = h && !prev_hit;
    prev_hit = h;
    smp_vld = 1'b1;
    smp_i = IW'(amp_i);
    smp_q = IW'(amp_q);
    @(posedge clk); @(negedge clk);
    smp_vld = 1'b0;
    chk(trig_out, 1'b0, "R9 pulse width");
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    chk(trig_out, exp, tag);
  endtask

  task automatic idle_noise(int n);
    for (int c = 0; c < n; c++) begin
      smp_i = IW'($urandom_range(4095));
      smp_q = IW'($urandom_range(4095));
      @(negedge clk);
      chk(trig_out, 1'b0, "R2 idle inputs ignored");
    end
    smp_i = '0;
    smp_q = '0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run exceeded cycle limit, expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(trig_out, 1'b0, "R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(trig_out, 1'b0, "R1 after reset");
    repeat (2) @(negedge clk);
    prev_hit = cur_hit();

    // R4: absolute rising
    cfg_rel = 1'b0; cfg_fall = 1'b0; cfg_k_abs = 4'd2; cfg_thr = 25'sd1000;
    do_arm();
    for (int s = 0; s < 4; s++) send(0, 0, "R4 abs quiet");
    for (int s = 0; s < 8; s++) send(100, 0, "R4 abs rise");
    // R2: strobe low with noisy inputs
    idle_noise(12);
    for (int s = 0; s < 2; s++) send(100, 0, "R2 state kept");
    for (int s = 0; s < 8; s++) send(0, 0, "R4 abs drop no fire");
    for (int s = 0; s < 6; s++) send(20, 30, "R4 abs re-rise");

    // R5: absolute falling
    cfg_fall = 1'b1; cfg_thr = 25'sd2000;
    do_arm();
    for (int s = 0; s < 8; s++) send(90, 40, "R5 abs high");
    for (int s = 0; s < 10; s++) send(5, 5, "R5 abs drop");

    // R6: relative, positive threshold
    cfg_fall = 1'b0; cfg_k_fast = 4'd1; cfg_k_slow = 4'd5; cfg_thr = 25'sd2000;
    set_mode(1'b1);
    for (int s = 0; s < 6; s++) send(10, 0, "R6 rel low");
    for (int s = 0; s < 12; s++) send(120, 0, "R6 rel step up");
    for (int s = 0; s < 12; s++) send(10, 0, "R6 rel step down no fire");

    // R7: relative, negative threshold
    cfg_thr = -25'sd2000;
    do_arm();
    for (int s = 0; s < 30; s++) send(120, 0, "R7 rel settle high");
    for (int s = 0; s < 12; s++) send(10, 0, "R7 rel step down");
    for (int s = 0; s < 8; s++) send(120, 0, "R7 rel step up no fire");

    // R8: falling request ignored in relative mode
    cfg_fall = 1'b1; cfg_thr = 25'sd2000;
    do_arm();
    for (int s = 0; s < 4; s++) send(10, 0, "R8 rel low");
    for (int s = 0; s < 10; s++) send(120, 0, "R8 rel up with fall req");
    for (int s = 0; s < 10; s++) send(0, 0, "R8 rel down with fall req");

    // R10: mode toggles clear a high average
    cfg_fall = 1'b0; cfg_k_abs = 4'd2; cfg_thr = 25'sd1000;
    set_mode(1'b0);
    for (int s = 0; s < 8; s++) send(100, 0, "R10 abs build");
    set_mode(1'b1);
    set_mode(1'b0);
    send(100, 0, "R10 fires after mode clear");

    // R10: arm coinciding with a sample; sample dropped
    for (int s = 0; s < 4; s++) send(100, 0, "R10 abs hold");
    arm = 1'b1; smp_vld = 1'b1; smp_i = 12'sd100; smp_q = '0;
    @(posedge clk); @(negedge clk);
    arm = 1'b0; smp_vld = 1'b0;
    chk(trig_out, 1'b0, "R10 quiet during clear");
    @(negedge clk);
    chk(trig_out, 1'b0, "R10 quiet after clear");
    repeat (2) @(negedge clk);
    model_clear();
    send(100, 0, "R10 fires after arm with sample");

    // R3: constrained random configurations and held steps
    for (int r = 0; r < 10; r++) begin
      bit nrel;
      int thr_v;
      nrel = 1'($urandom_range(1));
      cfg_fall = 1'($urandom_range(1));
      cfg_k_abs = KW'($urandom_range(6));
      cfg_k_fast = KW'($urandom_range(3));
      cfg_k_slow = KW'($urandom_range(9, 4));
      thr_v = int'($urandom_range(60000)) - 30000;
      cfg_thr = 25'(thr_v);
      if (nrel != cfg_rel) set_mode(nrel);
      do_arm();
      for (int b = 0; b < 6; b++) begin
        int ai;
        int aq;
        int len;
        ai = int'($urandom_range(400)) - 200;
        aq = int'($urandom_range(400)) - 200;
        if (b == 0) begin ai = 0; aq = 0; end
        if (b == 5) begin ai = -2048; aq = -2048; end
        len = int'($urandom_range(10, 3));
        for (int s = 0; s < len; s++) send(ai, aq, "R3 random filter track");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule